// File: doc/BRIEF.md
# Stop-Clock Throttle and Idle-State Arbiter

This block owns the active-low stop-clock request that goes to a processor core. It decides among four competing reasons to stop or release the core clock: a sleep-state entry request, a level-2 idle read, periodic software throttling and the halted (C1) idle condition. A fixed priority settles any conflict. Sleep entry beats everything. A level-2 read beats throttling. Throttling applies only while no sleep entry is pending.

Throttling runs from a free-running period counter of 2^PERIOD_W clocks. Stop-clock is held asserted for the first `duty_cnt` counts of each period. The duty value takes effect only at period rollover. Because the counter never restarts, throttling picks up again after a C2 exit on the same period phase, with a delay of at most one period.

After every stop-clock release, a short window output marks the clocks in which the shared floating-point-error pin may be sampled.

Top module: `stopclk_arbiter`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first clock after it, stop-clock is deasserted (high), the state code is 0 (C0) and the sample window is low. The period counter restarts from 0 and the latched duty value is cleared to 0.
- R2: In C0, `halt` moves the state to code 1 (C1) on the next clock. In C1, a low `halt` (with no other event) returns the state to code 0 on the next clock.
- R3: A `l2_rd` pulse in C0 or C1 moves the state to code 2 (C2 pending) and asserts stop-clock on the next clock. A `sg_ack` pulse in code 2 moves the state to code 3 (C2). Stop-clock stays asserted throughout codes 2 and 3.
- R4: A `brk_ev` pulse in code 2, or in a code 3 that was entered through a level-2 read, returns the state to code 0 and releases stop-clock on the next clock. A `brk_ev` pulse in C0 changes nothing.
- R5: While `thr_en` or `thr_force` is set and `slp_en` is clear, stop-clock is asserted on the clock after any clock in which the period count is below the latched duty value. The period count is (clocks since reset) mod 2^PERIOD_W.
- R6: `duty_cnt` is latched only on the clock in which the period count is at its maximum. A change at any other time does not affect stop-clock before that rollover.
- R7: While `slp_en` is set, the state is code 4 (sleep pending), stop-clock is deasserted whatever the throttle bits say, and `l2_rd` and `halt` are ignored. The clock after `slp_en` clears, the state is code 0.
- R8: A level-2 read that arrives while throttling is active keeps stop-clock asserted continuously, across duty boundaries and period rollovers, until a break event.
- R9: In C1, if stop-clock is asserted by throttling and `sg_ack` arrives, the state becomes code 3. It returns to code 1, with stop-clock released, on the clock after the first clock in which the throttle duty slot is over.
- R10: `ferr_win` is high exactly on the 6th, 7th and 8th clocks after stop-clock deasserts, and only while stop-clock stays deasserted.
- R11: After a C2 exit, throttling resumes on the phase of the uninterrupted period counter; the counter is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_en | input | 1 | Periodic throttle enable |
| thr_force | input | 1 | Forced throttle enable |
| slp_en | input | 1 | Sleep entry request, overrides all else |
| l2_rd | input | 1 | One-clock pulse: level-2 idle read |
| brk_ev | input | 1 | One-clock pulse: break event |
| halt | input | 1 | Core halted (C1) indication |
| sg_ack | input | 1 | One-clock pulse: stop-grant acknowledge from the core |
| duty_cnt | input | PERIOD_W | Stop-clock counts per period |
| stpclk_n | output | 1 | Stop-clock request to the core, active low |
| cstate | output | 3 | State code: 0 C0, 1 C1, 2 C2 pending, 3 C2, 4 sleep pending |
| ferr_win | output | 1 | Error-pin sample window |

## Verification
The bench builds the block with PERIOD_W = 4, which gives a 16-clock throttle period, and keeps the window bounds at 6 and 8. With that short period, many rollovers fit into a few hundred clocks. This makes the following directly observable: duty changes that land mid-period, a forced C2 hold that spans more than one full period, the phase-aligned restart after a break, and the window opening between throttle pulses.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [2:0] {
    ST_C0  = 3'd0,
    ST_C1  = 3'd1,
    ST_C2P = 3'd2,
    ST_C2  = 3'd3,
    ST_SLP = 3'd4
  } cst_e;

  // stop-clock slot: count below latched duty
  function automatic logic slot_hit(input int unsigned cnt, input int unsigned duty);
    return cnt < duty;
  endfunction

  // saturating increment
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  function automatic logic in_win(input int unsigned v, input int unsigned lo,
                                  input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/tc_period.sv
module tc_period #(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                thr_req,
  input  logic [PERIOD_W-1:0] duty_in,
  output logic [PERIOD_W-1:0] duty_q,
  output logic                rollover,
  output logic                slot
);
  logic [PERIOD_W-1:0] cnt_q;

  assign rollover = &cnt_q;
  assign slot     = thr_req & tc_pkg::slot_hit(32'(cnt_q), 32'(duty_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q <= cnt_q + PERIOD_W'(1);
      if (rollover) duty_q <= duty_in;
    end
  end
endmodule

// File: rtl/tc_cfsm.sv
module tc_cfsm
  import tc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic slp_en,
  input  logic l2_rd,
  input  logic brk_ev,
  input  logic halt,
  input  logic sg_ack,
  input  logic slot,
  output cst_e state_q,
  output logic stp_q,
  output logic stp_nxt
);
  cst_e st_n;
  logic c2l_q, c2l_n;   // C2 held by a level-2 read (vs. throttle C2)

  always_comb begin
    st_n  = state_q;
    c2l_n = c2l_q;
    if (slp_en) begin
      st_n  = ST_SLP;
      c2l_n = 1'b0;
    end else begin
      unique case (state_q)
        ST_SLP: st_n = ST_C0;
        ST_C0: begin
          if (l2_rd)     st_n = ST_C2P;
          else if (halt) st_n = ST_C1;
        end
        ST_C1: begin
          if (l2_rd) st_n = ST_C2P;
          else if (stp_q && sg_ack) begin
            st_n  = ST_C2;
            c2l_n = 1'b0;
          end else if (!halt) st_n = ST_C0;
        end
        ST_C2P: begin
          if (brk_ev) st_n = ST_C0;
          else if (sg_ack) begin
            st_n  = ST_C2;
            c2l_n = 1'b1;
          end
        end
        ST_C2: begin
          if (c2l_q) begin
            if (brk_ev) begin
              st_n  = ST_C0;
              c2l_n = 1'b0;
            end
          end else if (l2_rd) c2l_n = 1'b1;
          else if (!slot)      st_n  = ST_C1;
        end
        default: st_n = ST_C0;
      endcase
    end
    stp_nxt = (st_n == ST_C2P) | ((st_n == ST_C2) && c2l_n) | ((st_n != ST_SLP) && slot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_C0;
      c2l_q   <= 1'b0;
      stp_q   <= 1'b0;
    end else begin
      state_q <= st_n;
      c2l_q   <= c2l_n;
      stp_q   <= stp_nxt;
    end
  end
endmodule

// File: rtl/tc_errwin.sv
module tc_errwin #(
  parameter int WIN_OPEN  = 6,
  parameter int WIN_CLOSE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic stp_nxt,
  input  logic stp_q,
  output logic win
);
  localparam int unsigned SAT = WIN_CLOSE + 1;
  localparam int SW = $clog2(SAT + 1);

  logic [SW-1:0] since_q;

  assign win = !stp_q && tc_pkg::in_win(32'(since_q), WIN_OPEN, WIN_CLOSE);

  always_ff @(posedge clk) begin
    if (rst)          since_q <= SW'(SAT);
    else if (stp_nxt) since_q <= '0;
    else              since_q <= SW'(tc_pkg::sat_inc(32'(since_q), SAT));
  end
endmodule

// File: rtl/stopclk_arbiter.sv
module stopclk_arbiter #(
  parameter int PERIOD_W  = 10,
  parameter int WIN_OPEN  = 6,
  parameter int WIN_CLOSE = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                thr_en,
  input  logic                thr_force,
  input  logic                slp_en,
  input  logic                l2_rd,
  input  logic                brk_ev,
  input  logic                halt,
  input  logic                sg_ack,
  input  logic [PERIOD_W-1:0] duty_cnt,
  output logic                stpclk_n,
  output logic [2:0]          cstate,
  output logic                ferr_win
);
  logic                thr_req, slot, rollover, stp_q, stp_nxt;
  logic [PERIOD_W-1:0] duty_q;
  tc_pkg::cst_e        state_q;

  // sleep entry masks both throttle bits
  assign thr_req = (thr_en | thr_force) & ~slp_en;

  tc_period #(.PERIOD_W(PERIOD_W)) u_period (
    .clk(clk), .rst(rst), .thr_req(thr_req), .duty_in(duty_cnt),
    .duty_q(duty_q), .rollover(rollover), .slot(slot)
  );

  tc_cfsm u_fsm (
    .clk(clk), .rst(rst), .slp_en(slp_en), .l2_rd(l2_rd), .brk_ev(brk_ev),
    .halt(halt), .sg_ack(sg_ack), .slot(slot),
    .state_q(state_q), .stp_q(stp_q), .stp_nxt(stp_nxt)
  );

  tc_errwin #(.WIN_OPEN(WIN_OPEN), .WIN_CLOSE(WIN_CLOSE)) u_win (
    .clk(clk), .rst(rst), .stp_nxt(stp_nxt), .stp_q(stp_q), .win(ferr_win)
  );

  assign stpclk_n = ~stp_q;
  assign cstate   = state_q;
endmodule

// File: rtl/stopclk_arbiter_chk.sv
module stopclk_arbiter_chk #(
  parameter int PERIOD_W = 10
) (
  input logic                clk,
  input logic                rst,
  input logic                slp_en,
  input logic                brk_ev,
  input logic                sg_ack,
  input logic                stpclk_n,
  input logic [2:0]          cstate,
  input logic                ferr_win,
  input logic                rollover,
  input logic [PERIOD_W-1:0] duty_q
);
  AST_SLEEP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (cstate == 3'd4) |-> stpclk_n); // R7
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    slp_en |=> (cstate == 3'd4)); // R7
  AST_PEND_HOLDS_STP: assert property (@(posedge clk) disable iff (rst)
    (cstate == 3'd2) |-> !stpclk_n); // R3
  AST_C2_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    ((cstate == 3'd3) && ($past(cstate) != 3'd3)) |-> $past(sg_ack)); // R9
  AST_PEND_BREAK: assert property (@(posedge clk) disable iff (rst)
    ((cstate == 3'd2) && brk_ev && !slp_en) |=> (cstate == 3'd0) && stpclk_n); // R4
  AST_WIN_ONLY_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ferr_win |-> stpclk_n); // R10
  AST_DUTY_AT_ROLLOVER: assert property (@(posedge clk) disable iff (rst)
    !rollover |=> $stable(duty_q)); // R6
endmodule

bind stopclk_arbiter stopclk_arbiter_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk(clk), .rst(rst), .slp_en(slp_en), .brk_ev(brk_ev), .sg_ack(sg_ack),
  .stpclk_n(stpclk_n), .cstate(cstate), .ferr_win(ferr_win),
  .rollover(rollover), .duty_q(duty_q)
);

// File: tb/tb_stopclk_arbiter.sv
`timescale 1ns/1ps
module tb_stopclk_arbiter;
  localparam int PW = 4;
  localparam int PLEN = 1 << PW;
  localparam int WO = 6, WC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic thr_en = 0, thr_force = 0, slp_en = 0, l2_rd = 0, brk_ev = 0, halt = 0, sg_ack = 0;
  logic [PW-1:0] duty_cnt = '0;
  logic stpclk_n, ferr_win;
  logic [2:0] cstate;

  always #2 clk = ~clk;   // 250 MHz

  stopclk_arbiter #(.PERIOD_W(PW), .WIN_OPEN(WO), .WIN_CLOSE(WC)) dut (
    .clk(clk), .rst(rst), .thr_en(thr_en), .thr_force(thr_force), .slp_en(slp_en),
    .l2_rd(l2_rd), .brk_ev(brk_ev), .halt(halt), .sg_ack(sg_ack), .duty_cnt(duty_cnt),
    .stpclk_n(stpclk_n), .cstate(cstate), .ferr_win(ferr_win)
  );

  typedef struct {
    logic       stpn;
    logic [2:0] st;
    logic       win;
    string      req;
  } exp_t;

  exp_t exq[$];
  int total = 0, bad = 0;
  bit finished = 0;

  // bench-side view of the requirements
  int ph = 0, dq = 0, since = WC + 1;

  // monitor: pop and compare after each edge
  always @(posedge clk) begin
    #1;
    if (exq.size() > 0) begin
      exp_t e;
      e = exq.pop_front();
      total++;
      if (stpclk_n !== e.stpn || cstate !== e.st || ferr_win !== e.win) begin
        bad++;
        $display("FAIL %s: stpclk_n/cstate/ferr_win actual=%b/%0d/%b expected=%b/%0d/%b",
                 e.req, stpclk_n, cstate, ferr_win, e.stpn, e.st, e.win);
      end
    end
  end

  // driver: push expected outputs for the coming edge, then advance one clock
  task automatic cyc(input logic [2:0] st, input bit force_act, input string req);
    exp_t e;
    bit act, eff;
    eff = (thr_en | thr_force) & !slp_en;
    if (rst) begin
      ph = 0; dq = 0; since = WC + 1; act = 0;
    end else begin
      act = force_act | (eff && (ph < dq) && st != 3'd4);
      if (ph == PLEN - 1) dq = int'(duty_cnt);
      ph = (ph + 1) % PLEN;
      since = act ? 0 : ((since >= WC + 1) ? WC + 1 : since + 1);
    end
    e.stpn = !act;
    e.st   = st;
    e.win  = !act && since >= WO && since <= WC;
    e.req  = req;
    exq.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc(3'd0, 0, "R1");
    rst = 0;
    cyc(3'd0, 0, "R1");

    // C1 entry/exit
    halt = 1; cyc(3'd1, 0, "R2"); cyc(3'd1, 0, "R2");
    halt = 0; cyc(3'd0, 0, "R2");

    // level-2 read, grant, break, then error window
    l2_rd = 1; cyc(3'd2, 1, "R3"); l2_rd = 0;
    repeat (3) cyc(3'd2, 1, "R3");
    sg_ack = 1; cyc(3'd3, 1, "R3"); sg_ack = 0;
    repeat (2) cyc(3'd3, 1, "R3");
    brk_ev = 1; cyc(3'd0, 0, "R4"); brk_ev = 0;
    repeat (11) cyc(3'd0, 0, "R10");

    // break in C0 is a no-op; break while pending
    brk_ev = 1; cyc(3'd0, 0, "R4"); brk_ev = 0;
    l2_rd = 1; cyc(3'd2, 1, "R4"); l2_rd = 0;
    brk_ev = 1; cyc(3'd0, 0, "R4"); brk_ev = 0;

    // periodic throttling, enable then force
    duty_cnt = 4; thr_en = 1;
    repeat (40) cyc(3'd0, 0, "R5");
    thr_en = 0; thr_force = 1;
    repeat (20) cyc(3'd0, 0, "R5");
    thr_force = 0; thr_en = 1;

    // mid-period duty change
    while (ph != 6) cyc(3'd0, 0, "R5");
    duty_cnt = 9;
    repeat (30) cyc(3'd0, 0, "R6");
    duty_cnt = 4;
    repeat (20) cyc(3'd0, 0, "R6");

    // sleep masks throttle and idle requests
    slp_en = 1;
    repeat (20) cyc(3'd4, 0, "R7");
    l2_rd = 1; cyc(3'd4, 0, "R7"); l2_rd = 0;
    halt = 1; cyc(3'd4, 0, "R7"); halt = 0;
    slp_en = 0; cyc(3'd0, 0, "R7");

    // level-2 read while throttling: held through periods
    l2_rd = 1; cyc(3'd2, 1, "R8"); l2_rd = 0;
    sg_ack = 1; cyc(3'd3, 1, "R8"); sg_ack = 0;
    repeat (20) cyc(3'd3, 1, "R8");
    brk_ev = 1; cyc(3'd0, 0, "R4"); brk_ev = 0;
    repeat (20) cyc(3'd0, 0, "R11");

    // throttled C1 -> C2-like -> C1
    thr_en = 0; cyc(3'd0, 0, "R2");
    halt = 1; cyc(3'd1, 0, "R2");
    thr_en = 1; cyc(3'd1, 0, "R9");
    while (ph != 1) cyc(3'd1, 0, "R9");
    sg_ack = 1; cyc(3'd3, 0, "R9"); sg_ack = 0;
    cyc(3'd3, 0, "R9");
    cyc(3'd3, 0, "R9");
    cyc(3'd1, 0, "R9");
    halt = 0; thr_en = 0; cyc(3'd0, 0, "R2");
    repeat (12) cyc(3'd0, 0, "R10");

    @(posedge clk); #2;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule